// File: doc/BRIEF.md
# Two-Window Serial Control Register Bank

This block is a slave on a two-wire serial control bus (I2C, standard and fast mode up to 400 kHz). It holds a bank of 8-bit control registers that drive configuration signals into the rest of the chip. It also returns a small set of status bytes that other logic supplies. The bus lines are brought in through a short synchronizer and sampled by the system clock, which must run well above the bus rate. The block drives its data line only as a pull-low enable, so the open-drain pad sits outside it.

A host reaches the bank by naming the device, sending an 8-bit subaddress, and then either writing data bytes or issuing a repeated start and reading bytes back. The subaddress steps forward after every data byte in both directions, so a host can fill or scan a range in one transfer. Writes and reads use two separate, disjoint windows. The control bank accepts writes only. The status bytes can only be read, and a read anywhere outside the status window returns zero. One bit of the device address comes from a pin, so two copies of the block can share one bus.

Top module: `i2crb_top`

## Requirements
- R1: The block acknowledges only the 7-bit device address 1101S11, where S is the level of `addr_sel_i` at bit 2 of the 7-bit address. Any other address gets no acknowledge, and the transfer that follows leaves every register unchanged.
- R2: A write transfer is start, address with direction bit 0, subaddress, then data bytes. The block acknowledges every byte by pulling SDA low during the ninth clock, and each data byte is stored at the current subaddress.
- R3: The subaddress steps by one after every data byte, both written and read, and wraps from FFh to 00h.
- R4: Only subaddresses 00h to 21h can be written, and a byte written there changes only that register. Data bytes sent to any other subaddress are still acknowledged but are dropped.
- R5: A read transfer is a subaddress write, then a repeated start and the address with direction bit 1. Bytes come out MSB first. Subaddress 28h returns `status_i[7:0]`, 2Ah returns `status_i[15:8]`, 2Bh returns `status_i[23:16]` and 2Ch returns `status_i[31:24]`. Every other subaddress returns 00h.
- R6: When the host answers a read byte with no acknowledge, the block stops driving SDA and sends no further byte.
- R7: After reset, register 00h holds 80h, register 01h holds 40h and all other registers hold 00h. Register n appears on `ctrl_o[8n+7:8n]`, and SDA is released.
- R8: A stop or a start at any bit position ends the current transfer. A partly received byte is not stored, and bytes already stored are kept.
- R9: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Selects bit 2 of the device address |
| status_i | input | 32 | Four status bytes served in the read window |
| sda_oe_o | output | 1 | High to pull the data line low |
| ctrl_o | output | 272 | Control register bank, register n at bits 8n+7:8n |

## Verification
The bench writes the whole control window in one burst. It then starts bursts just below the window top and at FFh, so it can catch a design that writes past 21h, refuses to acknowledge discarded bytes, or fails to wrap the subaddress back onto register 00h. It reads every subaddress from 00h to 2Fh on its own and also in a burst that crosses the 29h gap, which exposes a mis-decoded status map or a read that leaks control data. It sends the address for the other pin setting and then flips the pin, which catches a hard-wired device address. It also breaks off transfers partway through a byte with a stop and with a repeated start, which shows up a design that stores half-shifted bytes or loses its place on the bus.

// File: rtl/i2crb_pkg.sv
package i2crb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_SUB,
    PH_WR,
    PH_RD
  } phase_t;

  localparam int unsigned STAT_BYTES = 4;

  // Read window decode: one lone status byte, then a run of three.
  function automatic logic [7:0] status_pick(input logic [7:0] sa,
                                             input logic [8*STAT_BYTES-1:0] st);
    case (sa)
      8'h28:   status_pick = st[7:0];
      8'h2A:   status_pick = st[15:8];
      8'h2B:   status_pick = st[23:16];
      8'h2C:   status_pick = st[31:24];
      default: status_pick = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/i2crb_sync.sv
module i2crb_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2crb_engine.sv
module i2crb_engine
  import i2crb_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h6B,
  parameter int unsigned SEL_BIT  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       addr_sel,
  input  logic [7:0] rd_data,
  output logic [7:0] sub_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       sda_oe_o
);
  phase_t     phase;
  logic [3:0] cnt;
  logic [7:0] rx, tx, sub;
  logic       mnack;
  logic [6:0] dev;
  logic [2:0] bitsel;
  logic       hit;

  always_comb begin
    dev          = DEV_ADDR;
    dev[SEL_BIT] = addr_sel;
  end

  assign hit    = (rx[7:1] == dev);
  assign bitsel = 3'(4'd7 - cnt);
  assign sub_o  = sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      rx        <= '0;
      tx        <= '0;
      sub       <= '0;
      mnack     <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        phase    <= PH_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        phase    <= PH_IDLE;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (cnt < 4'd8) begin
            rx  <= {rx[6:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (cnt == 4'd8) begin
            mnack <= sda_s;
            cnt   <= 4'd9;
          end
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            // ninth clock: acknowledge or hand the line to the host
            case (phase)
              PH_ADDR: sda_oe_o <= hit;
              PH_SUB:  begin sub <= rx; sda_oe_o <= 1'b1; end
              PH_WR:   begin wr_en_o <= 1'b1; wr_data_o <= rx; sda_oe_o <= 1'b1; end
              default: sda_oe_o <= 1'b0;
            endcase
          end else if (cnt == 4'd9) begin
            cnt      <= '0;
            sda_oe_o <= 1'b0;
            case (phase)
              PH_ADDR: begin
                if (!hit) phase <= PH_IDLE;
                else if (rx[0]) begin
                  phase    <= PH_RD;
                  tx       <= rd_data;
                  sda_oe_o <= ~rd_data[7];
                  sub      <= sub + 8'd1;
                end else phase <= PH_SUB;
              end
              PH_SUB: phase <= PH_WR;
              PH_WR:  sub <= sub + 8'd1;
              PH_RD: begin
                if (mnack) phase <= PH_IDLE;
                else begin
                  tx       <= rd_data;
                  sda_oe_o <= ~rd_data[7];
                  sub      <= sub + 8'd1;
                end
              end
              default: phase <= PH_IDLE;
            endcase
          end else if (phase == PH_RD && cnt != 4'd0) begin
            sda_oe_o <= ~tx[bitsel];
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2crb_bank.sv
module i2crb_bank #(
  parameter int unsigned         NREG      = 34,
  parameter logic [NREG*8-1:0]   RST_IMAGE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs_o[g*8 +: 8] <= RST_IMAGE[g*8 +: 8];
      else if (wr_en && wr_addr == 8'(g))
        regs_o[g*8 +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/i2crb_top.sv
module i2crb_top
  import i2crb_pkg::*;
#(
  parameter int unsigned       NREG      = 34,
  parameter logic [NREG*8-1:0] RST_IMAGE = {{(NREG-2){8'h00}}, 8'h40, 8'h80},
  parameter logic [6:0]        DEV_ADDR  = 7'h6B,
  parameter int unsigned       SEL_BIT   = 2,
  parameter int unsigned       SYNC_LEN  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scl_i,
  input  logic                    sda_i,
  input  logic                    addr_sel_i,
  input  logic [8*STAT_BYTES-1:0] status_i,
  output logic                    sda_oe_o,
  output logic [NREG*8-1:0]       ctrl_o
);
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] wr_sub, wr_byte, rd_byte;
  logic       wr_en;

  i2crb_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign rd_byte = status_pick(wr_sub, status_i);

  i2crb_engine #(.DEV_ADDR(DEV_ADDR), .SEL_BIT(SEL_BIT)) u_eng (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel_i), .rd_data(rd_byte), .sub_o(wr_sub),
    .wr_en_o(wr_en), .wr_data_o(wr_byte), .sda_oe_o(sda_oe_o)
  );

  i2crb_bank #(.NREG(NREG), .RST_IMAGE(RST_IMAGE)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_sub),
    .wr_data(wr_byte), .regs_o(ctrl_o)
  );
endmodule

// File: rtl/i2crb_chk.sv
module i2crb_chk #(
  parameter int unsigned NREG = 34
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [NREG*8-1:0] ctrl_o,
  input logic              wr_en,
  input logic [7:0]        wr_addr
);
  // R4
  win_guard_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= 8'(NREG)) |=> $stable(ctrl_o));
  // R2
  quiet_bank_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctrl_o));
  // R4
  one_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(ctrl_o ^ $past(ctrl_o)) <= 8);
  // R9
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);
endmodule

bind i2crb_top i2crb_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .ctrl_o(ctrl_o), .wr_en(wr_en), .wr_addr(wr_sub)
);

// File: tb/i2crb_top_tb.sv
module i2crb_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int NREG       = 34;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic addr_sel = 1'b1;
  logic [31:0] status = 32'hA5C3_1E77;
  logic sda_oe;
  logic [NREG*8-1:0] ctrl;
  logic sda_line;

  int vecs = 0, bad = 0, r9_viol = 0;
  logic done = 1'b0;
  logic [7:0] model [NREG];

  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2crb_top u_dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .status_i(status), .sda_oe_o(sda_oe), .ctrl_o(ctrl)
  );

  logic oe_q = 1'b0;
  always @(posedge clk) begin
    if (!rst && sda_oe != oe_q && m_scl) r9_viol++;
    oe_q <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rst_exp(input int i);
    return (i == 0) ? 8'h80 : (i == 1) ? 8'h40 : 8'h00;
  endfunction

  function automatic logic [7:0] st_exp(input logic [7:0] sa);
    case (sa)
      8'h28: return status[7:0];
      8'h2A: return status[15:8];
      8'h2B: return status[23:16];
      8'h2C: return status[31:24];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] devb(input logic sel, input logic rd);
    return {4'b1101, sel, 2'b11, rd};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    ack = ~sda_line; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); m_scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
    end
    m_sda = nack; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NREG; i++) chk(req, 32'(ctrl[i*8 +: 8]), 32'(model[i]));
  endtask

  // Writes a burst; every ack is checked against R2.
  task automatic write_burst(input logic [7:0] sa, input logic [7:0] d [], input logic sel);
    logic a;
    bus_start();
    send_byte(devb(sel, 1'b0), a); chk("R2 addr ack", 32'(a), 1);
    send_byte(sa, a);              chk("R2 sub ack", 32'(a), 1);
    for (int k = 0; k < d.size(); k++) begin
      send_byte(d[k], a); chk("R2 R4 data ack", 32'(a), 1);
      if (int'(8'(sa + 8'(k))) < NREG) model[8'(sa + 8'(k))] = d[k];
    end
    bus_stop();
  endtask

  task automatic read_burst(input logic [7:0] sa, input int n, input string req);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(devb(1'b1, 1'b0), a);
    send_byte(sa, a);
    bus_start();
    send_byte(devb(1'b1, 1'b1), a); chk("R5 read addr ack", 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k == n - 1, b);
      chk(req, 32'(b), 32'(st_exp(8'(sa + 8'(k)))));
    end
    tick(2);
    chk("R6 sda released after nack", 32'(sda_oe), 0);
    bus_stop();
  endtask

  initial begin
    logic a;
    logic [7:0] d [];
    for (int i = 0; i < NREG; i++) model[i] = rst_exp(i);
    tick(5);
    rst = 1'b0;
    tick(3);
    // R7 reset image and released line
    check_bank("R7 reset value");
    chk("R7 sda idle", 32'(sda_oe), 0);

    // R2 R3 full-window burst
    d = new[NREG];
    for (int i = 0; i < NREG; i++) d[i] = 8'(i * 37 + 5);
    write_burst(8'h00, d, 1'b1);
    check_bank("R2 R3 full burst");

    // R4 burst crossing the window top
    d = new[5];
    for (int k = 0; k < 5; k++) d[k] = 8'hC0 + 8'(k);
    write_burst(8'h1F, d, 1'b1);
    check_bank("R4 window edge");

    // R3 wrap FFh -> 00h
    d = new[2]; d[0] = 8'h11; d[1] = 8'h22;
    write_burst(8'hFF, d, 1'b1);
    check_bank("R3 wrap");

    // R4 write into the read window is dropped
    d = new[2]; d[0] = 8'h5A; d[1] = 8'hA5;
    write_burst(8'h28, d, 1'b1);
    check_bank("R4 status window write");

    // R1 other pin setting's address is refused
    bus_start();
    send_byte(devb(1'b0, 1'b0), a); chk("R1 foreign nack", 32'(a), 0);
    send_byte(8'h03, a);
    send_byte(8'hEE, a);
    bus_stop();
    check_bank("R1 foreign ignored");
    addr_sel = 1'b0;
    tick(4);
    bus_start();
    send_byte(devb(1'b1, 1'b0), a); chk("R1 old addr nack", 32'(a), 0);
    bus_stop();
    d = new[1]; d[0] = 8'h67;
    write_burst(8'h03, d, 1'b0);
    check_bank("R1 pin address");
    addr_sel = 1'b1;
    tick(4);

    // R5 single reads over the whole neighbourhood
    for (int sa = 0; sa < 48; sa++) read_burst(8'(sa), 1, "R5 single read");
    // R5 R3 burst read across the gap, then a new status value
    read_burst(8'h27, 7, "R5 R3 burst read");
    status = 32'h3C69_0FF1;
    tick(4);
    read_burst(8'h2A, 3, "R5 updated status");

    // R8 stop mid-byte keeps earlier byte
    bus_start();
    send_byte(devb(1'b1, 1'b0), a);
    send_byte(8'h05, a);
    send_byte(8'h3C, a); model[5] = 8'h3C;
    send_bits(8'hF0, 4);
    bus_stop();
    check_bank("R8 stop mid-byte");
    // R8 repeated start mid-byte
    bus_start();
    send_byte(devb(1'b1, 1'b0), a);
    send_byte(8'h07, a);
    send_bits(8'hAA, 3);
    bus_start();
    send_byte(devb(1'b1, 1'b0), a); chk("R8 restart ack", 32'(a), 1);
    send_byte(8'h08, a);
    send_byte(8'h99, a); model[8] = 8'h99;
    bus_stop();
    check_bank("R8 restart mid-byte");

    // R9 drive changes only while clock low
    chk("R9 sda edges", r9_viol, 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vecs++; bad++;
      $display("FAIL watchdog actual=expired expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule